// File: doc/BRIEF.md
# Frequency Sweep Synthesizer Core

This block is a numerically controlled oscillator with its own scan sequencer. Software first writes a profile into five registers: a start tuning word, a signed step word, an increment count, a dwell length and a mode word. Writing the mode word arms the block. A rising edge on the trigger input then starts the scan. The phase accumulator clears to zero, and the start word becomes the tuning word.

Each tuning word is held for a while and then the step is added to it. The mode word picks what ends the hold. In timer mode the hold lasts a programmed number of clock cycles. In external mode each fresh rising edge of the trigger input ends it. A step changes only the tuning word and never the accumulator, so the phase stays continuous across a step.

After the programmed number of increments the block raises a one-cycle end flag. It then keeps the final tuning word, and the accumulator keeps running at that frequency, until a reset. The accumulator drives a 10-bit amplitude code and a square-wave bit. The amplitude code is either a sine taken from a folded quarter-wave table or a linear triangle.

Top module: `sweep_dds`

## Requirements
- R1: After synchronous reset, `ftw_out`, `phase_out`, `scan_active` and `scan_end` are zero, the block is not armed, and all profile registers and mode bits are zero (timer mode, sine shape).
- R2: Writing address 4 (mode) arms the block. The first trigger rising edge seen while idle and armed starts the scan. In the next cycle `ftw_out` equals the start word (address 0), `phase_out` is 0, and `scan_active` is 1 if the count is non-zero. A trigger edge while not armed changes nothing.
- R3: While a scan runs or holds its final frequency, `phase_out` in each cycle equals its previous value plus the previous `ftw_out`, modulo 2^24. A frequency step never disturbs the accumulator.
- R4: In timer mode (mode bit 0 = 0), each tuning word is held for exactly D cycles, where D is the dwell register (address 3, 12 bits). The step word (address 1, two's complement, modulo 2^24) is then added. Trigger activity has no effect during the scan.
- R5: In external mode (mode bit 0 = 1), each trigger rising edge during a scan adds exactly one step, visible one cycle after the edge is sampled. Holding the trigger high does not step again.
- R6: After N increments, where N is the count register (address 2, 12 bits), `scan_end` is 1 for exactly one cycle, the cycle in which the final word first appears. `scan_active` drops in that same cycle. The final word then stays constant, and trigger edges are ignored until reset. With N = 0 the scan ends at once and holds the start word.
- R7: `msb_out` equals bit 23 of `phase_out`.
- R8: With mode bit 1 = 0, `wave_out` follows the sine curve, within 2 codes. Let k be phase bits 23:16 and s = sin(2π(k+0.5)/256). For k < 128 the code is 512 + 511·s. For k ≥ 128 it is 511 + 511·s.
- R9: With mode bit 1 = 1, `wave_out` is a triangle. Let p be phase bits 23:13. The code is p when p < 1024 and 2047 − p otherwise.
- R10: A dwell register of 0 behaves as a dwell of one cycle.
- R11: A reset in the middle of a scan returns the block to the state of R1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 start, 1 step, 2 count, 3 dwell, 4 mode |
| wr_data | input | 24 | Register write data |
| ctrl_in | input | 1 | Trigger: starts the armed scan; steps in external mode |
| ftw_out | output | 24 | Current tuning word |
| phase_out | output | 24 | Phase accumulator |
| wave_out | output | 10 | Sine or triangle amplitude code |
| msb_out | output | 1 | Square wave from the accumulator top bit |
| scan_active | output | 1 | Scan in progress |
| scan_end | output | 1 | One-cycle pulse when the final frequency is reached |

## Verification
Random timer-mode profiles vary the start word, the signed step, the count and the dwell. The trigger is toggled at random throughout, so a stray step caused by the trigger shows up at once against the closed-form word start + min(t/D, N)·step. Directed runs cover several corners. A dwell of zero separates the one-cycle floor from an off-by-one hold. A zero count checks the immediate end. A negative step that wraps through zero checks the modular add. An external-mode scan with a trigger held high for several cycles tells edge stepping apart from level stepping. Trigger edges before arming and after the end, and a reset in the middle of a scan, check the idle, hold and clear paths. The accumulator and both wave shapes are checked every cycle against a running phase sum kept in the bench.

// File: rtl/sweep_dds_pkg.sv
package sweep_dds_pkg;

  typedef enum logic [1:0] {
    SC_IDLE = 2'd0,
    SC_RUN  = 2'd1,
    SC_DONE = 2'd2
  } scan_state_e;

  localparam logic [2:0] REG_START = 3'd0;
  localparam logic [2:0] REG_STEP  = 3'd1;
  localparam logic [2:0] REG_COUNT = 3'd2;
  localparam logic [2:0] REG_DWELL = 3'd3;
  localparam logic [2:0] REG_MODE  = 3'd4;

  localparam int MODE_EXT_BIT = 0;
  localparam int MODE_TRI_BIT = 1;

  // Cycles a tuning word is held for a programmed dwell value (zero acts as one).
  function automatic int unsigned hold_cycles(input int unsigned dwell);
    return (dwell == 0) ? 1 : dwell;
  endfunction

  // Quarter-wave sine magnitude for table entry i of qn entries, sampled at
  // the entry midpoint, using a rational sine approximation in integer math.
  function automatic int quarter_sine(input int i, input int qn, input int amp);
    longint half;
    longint a;
    longint num;
    longint den;
    half = 4 * longint'(qn);
    a    = 2 * longint'(i) + 1;
    num  = 4 * a * (half - a);
    den  = (5 * half * half) / 4 - a * (half - a);
    return int'((longint'(amp) * num + den / 2) / den);
  endfunction

endpackage

// File: rtl/sweep_scan_seq.sv
module sweep_scan_seq
  import sweep_dds_pkg::*;
#(
  parameter int PW = 24,
  parameter int CW = 12,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [PW-1:0] wr_data,
  input  logic          ctrl_in,
  output logic [PW-1:0] ftw,
  output logic          start_fire,
  output logic          step_fire,
  output logic          scan_active,
  output logic          scan_done,
  output logic          scan_end,
  output logic          tri_sel
);

  scan_state_e   state;
  logic [PW-1:0] start_r;
  logic [PW-1:0] step_r;
  logic [CW-1:0] count_r;
  logic [DW-1:0] dwell_r;
  logic          ext_r;
  logic          armed_r;
  logic          ctrl_q;
  logic [CW-1:0] steps_done;
  logic [DW-1:0] dwell_cnt;
  logic          end_q;

  logic          ctrl_rise;
  logic          dwell_hit;
  logic          last_step;
  logic [CW:0]   steps_next;

  assign ctrl_rise  = ctrl_in & ~ctrl_q;
  assign start_fire = (state == SC_IDLE) && armed_r && ctrl_rise;
  assign dwell_hit  = (32'(dwell_cnt) + 32'd1) >= hold_cycles(32'(dwell_r));
  assign step_fire  = (state == SC_RUN) && (ext_r ? ctrl_rise : dwell_hit);
  assign steps_next = {1'b0, steps_done} + {{CW{1'b0}}, 1'b1};
  assign last_step  = step_fire && (steps_next == {1'b0, count_r});

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SC_IDLE;
      start_r    <= '0;
      step_r     <= '0;
      count_r    <= '0;
      dwell_r    <= '0;
      ext_r      <= 1'b0;
      tri_sel    <= 1'b0;
      armed_r    <= 1'b0;
      ctrl_q     <= 1'b0;
      steps_done <= '0;
      dwell_cnt  <= '0;
      ftw        <= '0;
      end_q      <= 1'b0;
    end else begin
      ctrl_q <= ctrl_in;
      end_q  <= 1'b0;
      case (state)
        SC_IDLE: begin
          if (start_fire) begin
            ftw        <= start_r;
            steps_done <= '0;
            dwell_cnt  <= '0;
            armed_r    <= 1'b0;
            if (count_r == '0) begin
              state <= SC_DONE;
              end_q <= 1'b1;
            end else begin
              state <= SC_RUN;
            end
          end
        end
        SC_RUN: begin
          if (step_fire) begin
            ftw        <= ftw + step_r;
            steps_done <= steps_next[CW-1:0];
            dwell_cnt  <= '0;
            if (last_step) begin
              state <= SC_DONE;
              end_q <= 1'b1;
            end
          end else begin
            dwell_cnt <= dwell_cnt + 1'b1;
          end
        end
        default: ;
      endcase
      if (wr_en) begin
        case (wr_addr)
          REG_START: start_r <= wr_data;
          REG_STEP:  step_r  <= wr_data;
          REG_COUNT: count_r <= wr_data[CW-1:0];
          REG_DWELL: dwell_r <= wr_data[DW-1:0];
          REG_MODE: begin
            ext_r   <= wr_data[MODE_EXT_BIT];
            tri_sel <= wr_data[MODE_TRI_BIT];
            armed_r <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign scan_active = (state == SC_RUN);
  assign scan_done   = (state == SC_DONE);
  assign scan_end    = end_q;

endmodule

// File: rtl/sweep_phase_acc.sv
module sweep_phase_acc #(
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic [PW-1:0] ftw,
  output logic [PW-1:0] phase
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      phase <= '0;
    end else if (en) begin
      phase <= phase + ftw;
    end
  end

endmodule

// File: rtl/sweep_wave_shaper.sv
module sweep_wave_shaper
  import sweep_dds_pkg::*;
#(
  parameter int AW = 10,
  parameter int LB = 6
) (
  input  logic [AW:0]   ph_top,
  input  logic          tri_sel,
  output logic [AW-1:0] wave
);

  localparam int TW  = AW + 1;
  localparam int QN  = 1 << LB;
  localparam int MID = 1 << (AW - 1);
  localparam int AMP = MID - 1;

  logic [AW-2:0] qtab [QN];

  for (genvar g = 0; g < QN; g++) begin : g_qtab
    assign qtab[g] = (AW-1)'(quarter_sine(g, QN, AMP));
  end

  logic [1:0]    quad;
  logic [LB-1:0] idx;
  logic [LB-1:0] fidx;
  logic [AW-1:0] qmag;
  logic [AW-1:0] sine_code;
  logic [AW-1:0] tri_ramp;
  logic [AW-1:0] tri_code;

  assign quad = ph_top[TW-1 -: 2];
  assign idx  = ph_top[TW-3 -: LB];
  assign fidx = quad[0] ? ~idx : idx;
  assign qmag = {1'b0, qtab[fidx]};

  assign sine_code = quad[1] ? (AW'(MID - 1) - qmag) : (AW'(MID) + qmag);

  assign tri_ramp = ph_top[TW-2:0];
  assign tri_code = ph_top[TW-1] ? ~tri_ramp : tri_ramp;

  assign wave = tri_sel ? tri_code : sine_code;

endmodule

// File: rtl/sweep_dds.sv
module sweep_dds #(
  parameter int PW = 24,
  parameter int AW = 10,
  parameter int CW = 12,
  parameter int DW = 12,
  parameter int LB = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [PW-1:0] wr_data,
  input  logic          ctrl_in,
  output logic [PW-1:0] ftw_out,
  output logic [PW-1:0] phase_out,
  output logic [AW-1:0] wave_out,
  output logic          msb_out,
  output logic          scan_active,
  output logic          scan_end
);

  localparam int TW = AW + 1;

  logic start_fire;
  logic step_fire;
  logic scan_done;
  logic tri_sel;
  logic acc_en;

  sweep_scan_seq #(.PW(PW), .CW(CW), .DW(DW)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .ctrl_in     (ctrl_in),
    .ftw         (ftw_out),
    .start_fire  (start_fire),
    .step_fire   (step_fire),
    .scan_active (scan_active),
    .scan_done   (scan_done),
    .scan_end    (scan_end),
    .tri_sel     (tri_sel)
  );

  assign acc_en = scan_active | scan_done;

  sweep_phase_acc #(.PW(PW)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .clr   (start_fire),
    .en    (acc_en),
    .ftw   (ftw_out),
    .phase (phase_out)
  );

  sweep_wave_shaper #(.AW(AW), .LB(LB)) u_shape (
    .ph_top  (phase_out[PW-1 -: TW]),
    .tri_sel (tri_sel),
    .wave    (wave_out)
  );

  assign msb_out = phase_out[PW-1];

endmodule

// File: rtl/sweep_dds_chk.sv
module sweep_dds_chk #(
  parameter int PW = 24
) (
  input logic          clk,
  input logic          rst,
  input logic [PW-1:0] ftw_out,
  input logic [PW-1:0] phase_out,
  input logic          scan_active,
  input logic          scan_done,
  input logic          scan_end,
  input logic          step_fire
);

  logic [PW-1:0] phase_sum;
  assign phase_sum = phase_out + ftw_out;

  a_r2_start_phase_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(scan_active) |-> (phase_out == '0));

  a_r3_phase_continuous: assert property (@(posedge clk) disable iff (rst)
    (scan_active || scan_done) |=> (phase_out == $past(phase_sum)));

  a_r4_word_held_between_steps: assert property (@(posedge clk) disable iff (rst)
    (scan_active && !step_fire) |=> $stable(ftw_out));

  a_r6_end_single_cycle: assert property (@(posedge clk) disable iff (rst)
    scan_end |=> !scan_end);

  a_r6_end_leaves_run: assert property (@(posedge clk) disable iff (rst)
    scan_end |-> (!scan_active && scan_done));

  a_r6_final_word_hold: assert property (@(posedge clk) disable iff (rst)
    scan_done |=> ($stable(ftw_out) && scan_done));

endmodule

bind sweep_dds sweep_dds_chk #(.PW(PW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ftw_out     (ftw_out),
  .phase_out   (phase_out),
  .scan_active (scan_active),
  .scan_done   (scan_done),
  .scan_end    (scan_end),
  .step_fire   (step_fire)
);

// File: tb/sweep_dds_bench.sv
module sweep_dds_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [23:0] wr_data = '0;
  logic        ctrl_in = 1'b0;
  logic [23:0] ftw_out;
  logic [23:0] phase_out;
  logic [9:0]  wave_out;
  logic        msb_out;
  logic        scan_active;
  logic        scan_end;

  int          n_run = 0;
  int          n_fail = 0;
  logic [23:0] ph_m = '0;
  bit          tri_m = 1'b0;

  always #5 clk = ~clk;

  sweep_dds u_sweep_dds (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .ctrl_in     (ctrl_in),
    .ftw_out     (ftw_out),
    .phase_out   (phase_out),
    .wave_out    (wave_out),
    .msb_out     (msb_out),
    .scan_active (scan_active),
    .scan_end    (scan_end)
  );

  task automatic chk(input string req, input longint got, input longint exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic chk_tol(input string req, input longint got, input longint exp, input int tol);
    n_run++;
    if (got > exp + tol || got < exp - tol) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d (+-%0d) at %0t", req, got, exp, tol, $time);
    end
  endtask

  function automatic int sine_ref(input logic [23:0] ph);
    int  k;
    real s;
    real v;
    k = int'(ph[23:16]);
    s = $sin(2.0 * 3.14159265358979 * (real'(k) + 0.5) / 256.0);
    v = (k < 128) ? 512.0 + 511.0 * s : 511.0 + 511.0 * s;
    return $rtoi(v + 0.5);
  endfunction

  function automatic int tri_ref(input logic [23:0] ph);
    int p;
    p = int'(ph >> 13);
    return (p < 1024) ? p : 2047 - p;
  endfunction

  // Sample between edges, compare all outputs, advance the bench phase sum.
  task automatic sample(input logic [23:0] ef, input bit ea, input bit ee, input string req);
    @(negedge clk);
    chk({req, " ftw"}, ftw_out, ef);
    chk("R3 phase", phase_out, ph_m);
    chk("R6 scan_active", scan_active, ea);
    chk("R6 scan_end", scan_end, ee);
    chk("R7 msb", msb_out, ph_m[23]);
    if (tri_m) chk("R9 triangle", wave_out, tri_ref(ph_m));
    else       chk_tol("R8 sine", wave_out, sine_ref(ph_m), 2);
    ph_m = ph_m + ef;
  endtask

  task automatic wr(input logic [2:0] a, input logic [23:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset(input string req);
    @(negedge clk);
    rst = 1'b1; ctrl_in = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    chk({req, " ftw zero"}, ftw_out, 0);
    chk({req, " phase zero"}, phase_out, 0);
    chk({req, " idle"}, scan_active, 0);
    chk({req, " no end"}, scan_end, 0);
    chk_tol({req, " sine at zero"}, wave_out, sine_ref('0), 2);
    ph_m = '0;
    tri_m = 1'b0;
  endtask

  task automatic load(input logic [23:0] f0, input logic [23:0] st, input int cnt,
                      input int dw, input bit ext, input bit tri_s);
    wr(3'd0, f0);
    wr(3'd1, st);
    wr(3'd2, 24'(cnt));
    wr(3'd3, 24'(dw));
    wr(3'd4, {22'd0, tri_s, ext});
    tri_m = tri_s;
  endtask

  task automatic start_scan();
    @(negedge clk);
    ctrl_in = 1'b1;
    ph_m = '0;
  endtask

  task automatic run_timer(input logic [23:0] f0, input logic [23:0] st, input int cnt,
                           input int dw, input bit tri_s, input bit jitter, input string req);
    int d;
    int total;
    int k;
    load(f0, st, cnt, dw, 1'b0, tri_s);
    start_scan();
    d = (dw == 0) ? 1 : dw;
    total = cnt * d;
    for (int t = 0; t <= total + 4; t++) begin
      k = t / d;
      if (k > cnt) k = cnt;
      sample(f0 + 24'(st * k), t < total, t == total, req);
      ctrl_in = jitter ? 1'($urandom_range(0, 1)) : 1'b0;
    end
    ctrl_in = 1'b0;
    do_reset("R11");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hang expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [23:0] f;
    logic [23:0] s;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 ftw", ftw_out, 0);
    chk("R1 phase", phase_out, 0);
    chk("R1 active", scan_active, 0);
    chk("R1 end", scan_end, 0);

    // R2: trigger without arming does nothing
    wr(3'd0, 24'h123456);
    @(negedge clk); ctrl_in = 1'b1;
    sample(24'h0, 1'b0, 1'b0, "R2 unarmed");
    ctrl_in = 1'b0;
    sample(24'h0, 1'b0, 1'b0, "R2 unarmed");

    // Directed timer corners
    run_timer(24'h010000, 24'h004000, 4, 0, 1'b0, 1'b1, "R10");
    run_timer(24'h0ABCDE, 24'h000100, 0, 5, 1'b1, 1'b1, "R6 zero count");
    run_timer(24'h000010, 24'hFFFFE0, 3, 2, 1'b1, 1'b0, "R4 wrap");
    run_timer(24'h020000, 24'h001234, 2, 1, 1'b0, 1'b1, "R4 dwell one");

    // Random timer profiles with trigger jitter
    for (int i = 0; i < 10; i++) begin
      run_timer(24'($urandom), 24'($urandom), int'($urandom_range(0, 5)),
                int'($urandom_range(0, 12)), 1'($urandom_range(0, 1)), 1'b1, "R4 random");
    end

    // R5 / R6: external stepping, level-high must not repeat
    f = 24'h200000;
    s = 24'hFF0000;
    load(f, s, 3, 7, 1'b1, 1'b1);
    start_scan();
    sample(f, 1'b1, 1'b0, "R2 start");
    ctrl_in = 1'b0;
    sample(f, 1'b1, 1'b0, "R5 no edge");
    sample(f, 1'b1, 1'b0, "R5 no edge");
    ctrl_in = 1'b1;
    sample(f + s, 1'b1, 1'b0, "R5 edge");
    sample(f + s, 1'b1, 1'b0, "R5 level held");
    sample(f + s, 1'b1, 1'b0, "R5 level held");
    ctrl_in = 1'b0;
    sample(f + s, 1'b1, 1'b0, "R5 low");
    ctrl_in = 1'b1;
    sample(f + 2 * s, 1'b1, 1'b0, "R5 edge");
    ctrl_in = 1'b0;
    sample(f + 2 * s, 1'b1, 1'b0, "R5 low");
    ctrl_in = 1'b1;
    sample(f + 3 * s, 1'b0, 1'b1, "R6 final");
    ctrl_in = 1'b0;
    sample(f + 3 * s, 1'b0, 1'b0, "R6 hold");
    ctrl_in = 1'b1;
    sample(f + 3 * s, 1'b0, 1'b0, "R6 edge ignored");
    ctrl_in = 1'b0;
    sample(f + 3 * s, 1'b0, 1'b0, "R6 hold");
    ctrl_in = 1'b1;
    sample(f + 3 * s, 1'b0, 1'b0, "R6 edge ignored");
    ctrl_in = 1'b0;
    do_reset("R1");

    // R11: reset in mid-scan, then the block is unarmed again
    load(24'h080000, 24'h001000, 5, 10, 1'b0, 1'b0);
    start_scan();
    for (int t = 0; t < 6; t++) begin
      sample(24'h080000, 1'b1, 1'b0, "R11 before reset");
      ctrl_in = 1'b0;
    end
    do_reset("R11");
    @(negedge clk); ctrl_in = 1'b1;
    sample(24'h0, 1'b0, 1'b0, "R2 unarmed after reset");
    ctrl_in = 1'b0;
    sample(24'h0, 1'b0, 1'b0, "R2 unarmed after reset");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule